// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block tells an asynchronous DRAM access sequencer when a refresh cycle is due and when the memory may first be used. After reset it waits out the power-up pause. It then requests a fixed number of initialisation refreshes and raises a ready flag once the last of them is acknowledged. From then on it owes one CAS-before-RAS refresh per interval, so that every row is covered within the retention period. The device counts rows itself, so no row address is produced.

The sequencer performs a refresh for each cycle in which it samples `ref_req` high with its own `ref_ack` high. Refreshes the sequencer cannot serve at once are kept as a small deficit and are drained back to back later. On request, the block brackets a self-refresh period with a burst of refreshes before and after it. It holds the sequencer in the self-refresh state (RAS and CAS low) for at least the minimum entry time. After that state ends it observes the self-refresh precharge time before the trailing burst starts. Every time interval is a nanosecond parameter that is converted to clock cycles at elaboration.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst_n` is low, `ref_req`, `init_done` and `sr_hold` are all 0.
- R2: After reset is released, `ref_req` stays 0 for exactly PWRUP_CYC rising edges (the power-up pause rounded up to whole cycles) and is 1 after edge PWRUP_CYC. `ref_ack` and `sr_req` have no effect during the pause.
- R3: During initialisation, `ref_req` stays 1 until INIT_N acknowledges (default 8) have been taken. `init_done` becomes 1 on the edge that takes the last one and stays 1 until reset. A `sr_req` raised before that time is not acted upon.
- R4: An edge with `ref_ack` high and `ref_req` low counts as no refresh and creates no credit against later requests.
- R5: In normal operation one refresh is owed every REFI_CYC cycles (the refresh interval rounded down). The first one raises `ref_req` REFI_CYC cycles after the edge that raised `init_done`, or after the edge that completed a trailing self-refresh burst.
- R6: `ref_req` stays 1 until it is acknowledged. Each edge with both `ref_req` and `ref_ack` high settles exactly one owed refresh, and `ref_req` falls when none is left.
- R7: The interval keeps running while a request waits. At most MAX_DEF refreshes (default 8) are kept owed, and further intervals that pass while the deficit is full are dropped.
- R8: When an interval ends on the same edge as an acknowledge, the owed count is unchanged.
- R9: `sr_req` high in normal operation clears the deficit and requests a burst of BURST_N refreshes. `sr_hold` rises on the edge that takes the last acknowledge of that burst. `ref_req` is 0 while `sr_hold` is 1.
- R10: `sr_hold` stays 1 for at least SR_MIN_CYC+1 cycles even if `sr_req` falls early. Once that time has elapsed, it falls on the first edge that samples `sr_req` low.
- R11: After `sr_hold` falls, `ref_req` stays 0 for RPS_CYC cycles (the self-refresh precharge time rounded up) and then requests a trailing burst of BURST_N refreshes. After that burst, normal interval operation restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ack | input | 1 | Sequencer performs one refresh on this edge |
| sr_req | input | 1 | Level request to enter and remain in self-refresh |
| ref_req | output | 1 | At least one refresh is owed |
| init_done | output | 1 | Power-up pause and initialisation refreshes are complete |
| sr_hold | output | 1 | Sequencer must keep RAS and CAS low (self-refresh) |

## Verification
The end of a refresh interval and an acknowledge of an earlier owed refresh can land on the same clock edge. The block must then neither lose nor double-count a refresh, and the deficit saturation sits in the same arithmetic. The bench provokes the coincidence directly by timing an acknowledge onto a known interval boundary. It also provokes it by chance, with long runs of random acknowledge densities that fill, hold and drain the deficit. A bench model of the owed count, built from the interval schedule and the acknowledges applied, judges `ref_req` on every cycle.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned PWRUP_NS  = 200000,
  parameter int unsigned REFI_NS   = 15600,
  parameter int unsigned SR_MIN_NS = 100000,
  parameter int unsigned RPS_NS    = 90,
  parameter int unsigned INIT_N    = 8,
  parameter int unsigned BURST_N   = 4096,
  parameter int unsigned MAX_DEF   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  input  logic sr_req,
  output logic ref_req,
  output logic init_done,
  output logic sr_hold
);

  function automatic int unsigned to_cyc(input int unsigned ns, input bit round_up);
    int unsigned c;
    c = round_up ? (ns * CLK_MHZ + 999) / 1000 : (ns * CLK_MHZ) / 1000;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  localparam int unsigned PWRUP_CYC  = to_cyc(PWRUP_NS, 1'b1);
  localparam int unsigned REFI_CYC   = to_cyc(REFI_NS, 1'b0);
  localparam int unsigned SR_MIN_CYC = to_cyc(SR_MIN_NS, 1'b1);
  localparam int unsigned RPS_CYC    = to_cyc(RPS_NS, 1'b1);
  localparam int unsigned TMAX = max2(max2(PWRUP_CYC, REFI_CYC), max2(SR_MIN_CYC, RPS_CYC));
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned CW   = $clog2(max2(INIT_N, BURST_N) + 1);
  localparam int unsigned DW   = $clog2(MAX_DEF + 1);

  typedef enum logic [2:0] {
    S_PWRUP, S_INIT, S_RUN, S_PRE, S_HOLD, S_RPS, S_POST
  } state_t;

  state_t          st;
  logic [TW-1:0]   tmr;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   pend;
  logic [DW-1:0]   pend_nxt;
  logic            tick;
  logic            drain;
  logic            burst_st;

  assign burst_st = (st == S_INIT) || (st == S_PRE) || (st == S_POST);
  assign tick     = (st == S_RUN) && (tmr == TW'(REFI_CYC - 1));
  assign drain    = ref_ack && (pend != '0);

  always_comb begin
    pend_nxt = pend;
    if (tick && !drain) begin
      if (pend != DW'(MAX_DEF)) pend_nxt = pend + 1'b1;
    end else if (!tick && drain) begin
      pend_nxt = pend - 1'b1;
    end
  end

  assign ref_req = (st == S_RUN) ? (pend != '0) : (burst_st && (cnt != '0));
  assign sr_hold = (st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_PWRUP;
      tmr       <= '0;
      cnt       <= '0;
      pend      <= '0;
      init_done <= 1'b0;
    end else begin
      case (st)
        S_PWRUP: begin
          if (tmr == TW'(PWRUP_CYC - 1)) begin
            st  <= S_INIT;
            tmr <= '0;
            cnt <= CW'(INIT_N);
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_INIT, S_PRE, S_POST: begin
          if (ref_ack) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
              tmr  <= '0;
              pend <= '0;
              if (st == S_PRE) begin
                st <= S_HOLD;
              end else begin
                st        <= S_RUN;
                init_done <= 1'b1;
              end
            end
          end
        end
        S_RUN: begin
          if (sr_req) begin
            st   <= S_PRE;
            cnt  <= CW'(BURST_N);
            pend <= '0;
            tmr  <= '0;
          end else begin
            tmr  <= tick ? '0 : tmr + 1'b1;
            pend <= pend_nxt;
          end
        end
        S_HOLD: begin
          if (tmr == TW'(SR_MIN_CYC)) begin
            if (!sr_req) begin
              st  <= S_RPS;
              tmr <= '0;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_RPS: begin
          if (tmr == TW'(RPS_CYC - 1)) begin
            st  <= S_POST;
            tmr <= '0;
            cnt <= CW'(BURST_N);
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_PWRUP;
      endcase
    end
  end

endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned CLK_MHZ   = 100,
  parameter int unsigned PWRUP_NS  = 200000,
  parameter int unsigned SR_MIN_NS = 100000,
  parameter int unsigned MAX_DEF   = 8,
  parameter int unsigned DW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_ack,
  input logic          ref_req,
  input logic          init_done,
  input logic          sr_hold,
  input logic [DW-1:0] pend
);

  localparam int unsigned PW_CYC = ((PWRUP_NS * CLK_MHZ + 999) / 1000 == 0) ? 1 : (PWRUP_NS * CLK_MHZ + 999) / 1000;
  localparam int unsigned SM_CYC = ((SR_MIN_NS * CLK_MHZ + 999) / 1000 == 0) ? 1 : (SR_MIN_NS * CLK_MHZ + 999) / 1000;

  int unsigned since_rst;
  int unsigned hold_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
      hold_len  <= 0;
    end else begin
      if (since_rst < PW_CYC) since_rst <= since_rst + 1;
      hold_len <= sr_hold ? hold_len + 1 : 0;
    end
  end

  a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < PW_CYC) |-> !ref_req);

  a_r3_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  a_r3_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> $past(ref_ack && ref_req));

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack) |=> ref_req);

  a_r7_deficit_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= DW'(MAX_DEF));

  a_r9_quiet_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    sr_hold |-> (!ref_req && init_done));

  a_r10_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_hold) |-> (hold_len >= SM_CYC + 1));

endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .CLK_MHZ(CLK_MHZ), .PWRUP_NS(PWRUP_NS), .SR_MIN_NS(SR_MIN_NS),
  .MAX_DEF(MAX_DEF), .DW(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_req(ref_req),
  .init_done(init_done), .sr_hold(sr_hold), .pend(pend)
);

// File: tb/tb_dram_refresh_sched.sv
module tb_dram_refresh_sched;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 1000 / CLK_PERIOD;
  localparam int P_PWRUP_NS = 2000;
  localparam int P_REFI_NS  = 1560;
  localparam int P_SRMIN_NS = 1000;
  localparam int P_RPS_NS   = 90;
  localparam int P_INIT     = 8;
  localparam int P_BURST    = 16;
  localparam int P_DEF      = 8;

  function automatic int cyc_of(input int ns, input bit up);
    int c;
    c = up ? (ns * MHZ + 999) / 1000 : (ns * MHZ) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PWRUP = cyc_of(P_PWRUP_NS, 1'b1);
  localparam int REFI  = cyc_of(P_REFI_NS, 1'b0);
  localparam int SRMIN = cyc_of(P_SRMIN_NS, 1'b1);
  localparam int RPS   = cyc_of(P_RPS_NS, 1'b1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_ack = 1'b0;
  logic sr_req = 1'b0;
  logic ref_req, init_done, sr_hold;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit model_on = 1'b0;
  int e_base = 0;
  int exp_pend = 0;
  bit done = 1'b0;

  dram_refresh_sched #(
    .CLK_MHZ(MHZ), .PWRUP_NS(P_PWRUP_NS), .REFI_NS(P_REFI_NS),
    .SR_MIN_NS(P_SRMIN_NS), .RPS_NS(P_RPS_NS), .INIT_N(P_INIT),
    .BURST_N(P_BURST), .MAX_DEF(P_DEF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .sr_req(sr_req),
    .ref_req(ref_req), .init_done(init_done), .sr_hold(sr_hold)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int model_next(input int p, input bit tk, input bit ack);
    bit dr;
    dr = ack && (p != 0);
    if (tk && !dr) return (p == P_DEF) ? p : p + 1;
    if (!tk && dr) return p - 1;
    return p;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (model_on)
      exp_pend = model_next(exp_pend, (cyc > e_base) && ((cyc - e_base) % REFI == 0), ref_ack);
  end

  always @(negedge clk) begin
    if (model_on && !done)
      chk(ref_req == (exp_pend != 0), "R6 R7 R8 model ref_req", int'(ref_req), int'(exp_pend != 0));
  end

  task automatic wait_req(input int lim, output int n);
    n = 0;
    while (!ref_req && n < lim) begin step(); n++; end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    int n;
    int t;
    void'($urandom(1234));
    step(3);
    chk(!ref_req && !init_done && !sr_hold, "R1 reset outputs", {ref_req, init_done, sr_hold}, 0);

    rst_n = 1'b1;
    n = 0;
    while (!ref_req && n < 1000) begin
      step(); n++;
      if (n == 50) begin ref_ack = 1'b1; sr_req = 1'b1; end
      if (n == 51) begin ref_ack = 1'b0; sr_req = 1'b0; end
    end
    chk(n == PWRUP, "R2 power-up pause", n, PWRUP);

    ref_ack = 1'b1;
    step(P_INIT - 1);
    chk(ref_req && !init_done, "R3 before last init ack", {ref_req, init_done}, 2);
    step();
    ref_ack = 1'b0;
    chk(init_done && !ref_req, "R3 init done after last ack", {init_done, ref_req}, 2);
    e_base = cyc;
    exp_pend = 0;
    model_on = 1'b1;

    step(5);
    ref_ack = 1'b1;
    step(3);
    ref_ack = 1'b0;
    chk(!ref_req && !sr_hold, "R3 early sr_req ignored", {ref_req, sr_hold}, 0);
    wait_req(2 * REFI, n);
    chk(cyc - e_base == REFI, "R5 first interval", cyc - e_base, REFI);
    step(20);
    chk(ref_req, "R6 request held", int'(ref_req), 1);
    ref_ack = 1'b1; step(); ref_ack = 1'b0;
    chk(!ref_req, "R4 one ack settles one refresh", int'(ref_req), 0);

    step(9 * REFI);
    while ((cyc - e_base) % REFI != 0) step();
    ref_ack = 1'b1;
    step(P_DEF - 1);
    chk(ref_req, "R7 deficit not yet drained", int'(ref_req), 1);
    step();
    ref_ack = 1'b0;
    chk(!ref_req, "R7 deficit capped", int'(ref_req), 0);

    step();
    while ((cyc - e_base) % REFI != 0) step();
    chk(ref_req, "R5 next interval", int'(ref_req), 1);
    while ((cyc - e_base) % REFI != REFI - 1) step();
    ref_ack = 1'b1; step(); ref_ack = 1'b0;
    chk(ref_req, "R8 tick and ack same edge", int'(ref_req), 1);
    ref_ack = 1'b1; step(); ref_ack = 1'b0;
    chk(!ref_req, "R8 single refresh left", int'(ref_req), 0);

    for (int ph = 0; ph < 3; ph++) begin
      int pct;
      pct = (ph == 0) ? 2 : (ph == 1) ? 30 : 80;
      for (int i = 0; i < 1500; i++) begin
        ref_ack = (($urandom % 100) < pct);
        step();
      end
    end
    ref_ack = 1'b1;
    while (ref_req) step();
    ref_ack = 1'b0;
    model_on = 1'b0;

    sr_req = 1'b1;
    step();
    chk(ref_req && !sr_hold, "R9 entry burst requested", {ref_req, sr_hold}, 2);
    ref_ack = 1'b1;
    step(P_BURST - 1);
    chk(ref_req && !sr_hold, "R9 burst not complete", {ref_req, sr_hold}, 2);
    step();
    ref_ack = 1'b0;
    sr_req = 1'b0;
    chk(sr_hold && !ref_req, "R9 hold after burst", {sr_hold, ref_req}, 2);
    n = 1;
    while (sr_hold && n < 10 * SRMIN) begin
      ref_ack = ~ref_ack;
      step();
      if (sr_hold) begin
        n++;
        chk(!ref_req, "R9 no request in self-refresh", int'(ref_req), 0);
      end
    end
    ref_ack = 1'b0;
    chk(n == SRMIN + 1, "R10 minimum hold", n, SRMIN + 1);
    t = cyc;
    wait_req(100, n);
    chk(cyc - t == RPS, "R11 exit precharge", cyc - t, RPS);
    ref_ack = 1'b1;
    step(P_BURST);
    ref_ack = 1'b0;
    chk(!ref_req && !sr_hold, "R11 exit burst complete", {ref_req, sr_hold}, 0);
    t = cyc;
    wait_req(2 * REFI, n);
    chk(cyc - t == REFI, "R11 interval restarts", cyc - t, REFI);
    ref_ack = 1'b1; step(); ref_ack = 1'b0;

    sr_req = 1'b1;
    step();
    ref_ack = 1'b1;
    step(P_BURST);
    ref_ack = 1'b0;
    step(3 * SRMIN);
    chk(sr_hold, "R10 hold kept while requested", int'(sr_hold), 1);
    sr_req = 1'b0;
    step();
    chk(!sr_hold, "R10 exit on first low sample", int'(sr_hold), 0);
    wait_req(100, n);
    ref_ack = 1'b1;
    step(P_BURST);
    ref_ack = 1'b0;
    chk(!ref_req && init_done, "R11 second exit burst", {ref_req, init_done}, 1);

    step(7);
    rst_n = 1'b0;
    step();
    chk(!ref_req && !init_done && !sr_hold, "R1 reset mid-run", {ref_req, init_done, sr_hold}, 0);
    finish_run();
  end
endmodule